// File: doc/BRIEF.md
# I/O Bank Freeze/Thaw Sequencer

This block parks a group of general-purpose I/O channels in a safe, frozen condition and later returns them to normal operation. Each channel has five pad controls: slew enable, weak pull-up enable, high-impedance control, bus-hold control and a configuration-done flag. A single-cycle freeze or thaw request starts an ordered walk over the channels. Within each channel the controls change in groups, and a minimum settle time lies between consecutive groups.

The settle time is counted in clock cycles. The count is derived from a settle time in nanoseconds and from the clock period, and both are parameters. While a walk is in progress the block reports busy and ignores further requests. A per-channel frozen flag tells the surrounding logic which channels are currently parked.

Freezing and thawing are deliberately asymmetric. Freeze drops three controls together and then drops the remaining two. Thaw raises the controls in three groups, and the slew control is released last.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset every control output is 0, every `frozen` bit is 1 and `busy` is 0.
- R2: `slew_en_n`, `pullup_en_n`, `hiz_n` and `hold_n` are active-low, so 0 means the frozen condition. `cfg_done` is active-high, so 1 means configured.
- R3: A channel freezes in two steps. First `slew_en_n`, `pullup_en_n` and `hiz_n` go to 0 together. Then, no fewer than W cycles later, `hold_n` and `cfg_done` go to 0 together.
- R4: A channel thaws in three steps. First `hold_n` and `cfg_done` go to 1. W cycles later `pullup_en_n` and `hiz_n` go to 1. W cycles after that `slew_en_n` goes to 1.
- R5: Channels are processed in ascending index order. A channel's first step is applied one cycle after the previous channel's last step.
- R6: W equals ceil(SETTLE_NS / CLK_PERIOD_NS), with a minimum of 1 cycle.
- R7: A channel's `frozen` bit is set at the same clock edge as its last freeze step, and cleared at the same edge as its last thaw step. It changes at no other time.
- R8: `busy` goes to 1 in the cycle after an accepted request. The first step of channel 0 takes effect one cycle later. `busy` returns to 0 at the edge that applies the last step of the highest channel. Outputs never change while `busy` is 0.
- R9: A freeze or thaw request that arrives while `busy` is 1 has no effect on any output.
- R10: A request whose target state the channels already have still runs the full sequence, so `busy` stays high for the full sequence length.
- R11: If freeze and thaw are requested in the same cycle, the freeze sequence is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_req | input | 1 | One-cycle pulse that requests the freeze sequence |
| thaw_req | input | 1 | One-cycle pulse that requests the thaw sequence |
| slew_en_n | output | NUM_CH | Slew enable per channel, active-low |
| pullup_en_n | output | NUM_CH | Weak pull-up enable per channel, active-low |
| hiz_n | output | NUM_CH | High-impedance control per channel, active-low |
| hold_n | output | NUM_CH | Bus-hold control per channel, active-low |
| cfg_done | output | NUM_CH | Configuration done per channel, active-high |
| busy | output | 1 | High while a sequence is in progress |
| frozen | output | NUM_CH | Per-channel frozen status |

## Verification
The bench sends a freeze to channels that are already frozen, which shows that a redundant request still holds `busy` for the full sequence length. It then sends a genuine thaw, where every group edge and its cycle are compared, so any misordering of the groups or any wrong settle count is caught. A redundant thaw and a genuine freeze each get an opposite request injected mid-sequence, and any stray output change exposes a request that should have been ignored. A simultaneous freeze-and-thaw issued from the thawed state separates freeze priority from thaw priority, because only the freeze produces visible edges.

// File: rtl/io_freeze_seq.sv
module io_freeze_seq #(
  parameter int NUM_CH        = 3,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SETTLE_NS     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_req,
  input  logic              thaw_req,
  output logic [NUM_CH-1:0] slew_en_n,
  output logic [NUM_CH-1:0] pullup_en_n,
  output logic [NUM_CH-1:0] hiz_n,
  output logic [NUM_CH-1:0] hold_n,
  output logic [NUM_CH-1:0] cfg_done,
  output logic              busy,
  output logic [NUM_CH-1:0] frozen
);
  localparam int WAIT_RAW = (SETTLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int CW       = $clog2(WAIT_CYC + 1);
  localparam int CHW      = (NUM_CH < 2) ? 1 : $clog2(NUM_CH);

  logic           thawing;
  logic [CHW-1:0] ch;
  logic [1:0]     step;
  logic [CW-1:0]  cnt;

  wire [1:0] last_step = thawing ? 2'd2 : 2'd1;
  wire       last_ch   = (ch == CHW'(NUM_CH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slew_en_n   <= '0;
      pullup_en_n <= '0;
      hiz_n       <= '0;
      hold_n      <= '0;
      cfg_done    <= '0;
      frozen      <= '1;
      busy        <= 1'b0;
      thawing     <= 1'b0;
      ch          <= '0;
      step        <= '0;
      cnt         <= '0;
    end else if (!busy) begin
      if (freeze_req || thaw_req) begin
        busy    <= 1'b1;
        thawing <= !freeze_req;
        ch      <= '0;
        step    <= '0;
        cnt     <= '0;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      case ({thawing, step})
        3'b000: begin
          slew_en_n[ch]   <= 1'b0;
          pullup_en_n[ch] <= 1'b0;
          hiz_n[ch]       <= 1'b0;
        end
        3'b001: begin
          hold_n[ch]   <= 1'b0;
          cfg_done[ch] <= 1'b0;
        end
        3'b100: begin
          hold_n[ch]   <= 1'b1;
          cfg_done[ch] <= 1'b1;
        end
        3'b101: begin
          pullup_en_n[ch] <= 1'b1;
          hiz_n[ch]       <= 1'b1;
        end
        3'b110: slew_en_n[ch] <= 1'b1;
        default: ;
      endcase
      if (step == last_step) begin
        step       <= '0;
        frozen[ch] <= !thawing;
        if (last_ch) busy <= 1'b0;
        else         ch   <= ch + 1'b1;
      end else begin
        step <= step + 1'b1;
        cnt  <= CW'(WAIT_CYC - 1);
      end
    end
  end
endmodule

// File: rtl/io_freeze_seq_chk.sv
module io_freeze_seq_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze_req,
  input logic              thaw_req,
  input logic [NUM_CH-1:0] slew_en_n,
  input logic [NUM_CH-1:0] pullup_en_n,
  input logic [NUM_CH-1:0] hiz_n,
  input logic [NUM_CH-1:0] hold_n,
  input logic [NUM_CH-1:0] cfg_done,
  input logic              busy,
  input logic [NUM_CH-1:0] frozen
);
  // R8
  idle_outputs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({slew_en_n, pullup_en_n, hiz_n, hold_n, cfg_done}));

  // R7
  idle_frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(frozen));

  // R8
  busy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(freeze_req || thaw_req));

  // R3
  hold_after_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~hold_n & (slew_en_n | pullup_en_n | hiz_n)) == '0);

  // R4
  slew_released_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slew_en_n & ~(pullup_en_n & hiz_n & hold_n)) == '0);

  // R2
  hold_cfg_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_n == cfg_done);

  // R7
  frozen_slew_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen & slew_en_n) == '0);
endmodule

bind io_freeze_seq io_freeze_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
  .slew_en_n(slew_en_n), .pullup_en_n(pullup_en_n), .hiz_n(hiz_n),
  .hold_n(hold_n), .cfg_done(cfg_done), .busy(busy), .frozen(frozen)
);

// File: tb/io_freeze_seq_test.sv
module io_freeze_seq_test;
  localparam int CLK_NS = 10;
  localparam int NCH    = 3;
  localparam int SETTLE = 20;
  localparam int W      = ((SETTLE + CLK_NS - 1) / CLK_NS) < 1 ? 1 : (SETTLE + CLK_NS - 1) / CLK_NS;
  localparam int VW     = 1 + 6 * NCH;

  typedef struct {
    int             t;
    logic [VW-1:0]  v;
    string          tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, freeze_req = 1'b0, thaw_req = 1'b0;
  logic [NCH-1:0] slew_en_n, pullup_en_n, hiz_n, hold_n, cfg_done, frozen;
  logic busy;

  io_freeze_seq #(.NUM_CH(NCH), .CLK_PERIOD_NS(CLK_NS), .SETTLE_NS(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
    .slew_en_n(slew_en_n), .pullup_en_n(pullup_en_n), .hiz_n(hiz_n),
    .hold_n(hold_n), .cfg_done(cfg_done), .busy(busy), .frozen(frozen)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  item_t q[$];
  logic [VW-1:0] last_pushed, prev_obs;
  bit mon_on = 0;

  logic m_busy;
  logic [NCH-1:0] m_slew, m_pull, m_hiz, m_hold, m_cfg, m_frz;

  function automatic logic [VW-1:0] pack_model();
    return {m_busy, m_frz, m_slew, m_pull, m_hiz, m_hold, m_cfg};
  endfunction

  function automatic logic [VW-1:0] pack_obs();
    return {busy, frozen, slew_en_n, pullup_en_n, hiz_n, hold_n, cfg_done};
  endfunction

  function automatic void emit(int t, string tag);
    item_t it;
    if (pack_model() != last_pushed) begin
      it.t = t; it.v = pack_model(); it.tag = tag;
      q.push_back(it);
      last_pushed = pack_model();
    end
  endfunction

  // model of one step: R2 R3 R4
  function automatic void apply(bit frz, int c, int s);
    if (frz) begin
      if (s == 0) begin m_slew[c] = 0; m_pull[c] = 0; m_hiz[c] = 0; end
      else begin m_hold[c] = 0; m_cfg[c] = 0; m_frz[c] = 1; end
    end else begin
      if (s == 0) begin m_hold[c] = 1; m_cfg[c] = 1; end
      else if (s == 1) begin m_pull[c] = 1; m_hiz[c] = 1; end
      else begin m_slew[c] = 1; m_frz[c] = 0; end
    end
  endfunction

  task automatic run_seq(bit do_frz, bit do_thaw, bit poke, string tag);
    int c, t, nsteps, t_end;
    bit frz;
    @(negedge clk);
    c = cyc;
    freeze_req = do_frz; thaw_req = do_thaw;
    frz = do_frz;                         // R11 freeze wins
    m_busy = 1; emit(c + 1, tag);         // R8
    nsteps = frz ? 2 : 3;
    t = c + 2;
    for (int ch = 0; ch < NCH; ch++) begin  // R5
      for (int s = 0; s < nsteps; s++) begin
        apply(frz, ch, s);
        if (ch == NCH - 1 && s == nsteps - 1) m_busy = 0;
        emit(t, tag);
        t_end = t;
        t += (s < nsteps - 1) ? W : 1;      // R6
      end
    end
    @(negedge clk);
    freeze_req = 0; thaw_req = 0;
    if (poke) begin                        // R9
      repeat (2) @(negedge clk);
      if (frz) thaw_req = 1; else freeze_req = 1;
      @(negedge clk);
      freeze_req = 0; thaw_req = 0;
      @(negedge clk);
      if (frz) freeze_req = 1; else thaw_req = 1;
      @(negedge clk);
      freeze_req = 0; thaw_req = 0;
    end
    while (cyc < t_end + 3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      logic [VW-1:0] cur;
      item_t it;
      cur = pack_obs();
      if (cur !== prev_obs) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R9: unexpected change at cycle %0d actual %h expected %h", cyc, cur, prev_obs);
        end else begin
          it = q.pop_front();
          if (it.v !== cur || it.t != cyc) begin
            fails++;
            $display("FAIL %s: actual %h at cycle %0d expected %h at cycle %0d", it.tag, cur, cyc, it.v, it.t);
          end
        end
        prev_obs = cur;
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    m_busy = 0; m_slew = '0; m_pull = '0; m_hiz = '0; m_hold = '0; m_cfg = '0; m_frz = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (pack_obs() !== pack_model()) begin
      fails++;
      $display("FAIL R1: actual %h expected %h", pack_obs(), pack_model());
    end
    last_pushed = pack_model();
    prev_obs    = pack_obs();
    mon_on      = 1;
    run_seq(1, 0, 0, "R10_redundant_freeze");
    run_seq(0, 1, 0, "R4_R5_R6_R7_R8_thaw");
    run_seq(0, 1, 1, "R9_R10_thaw_poked");
    run_seq(1, 1, 0, "R11_both");
    run_seq(0, 1, 0, "R4_thaw");
    run_seq(1, 0, 1, "R3_R9_freeze_poked");
    repeat (5) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R8: actual %0d pending edges expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule